// File: doc/BRIEF.md
# Command and Argument Word Collector

This block is the register-side front end of a command engine. Software writes a command code to one register and then its argument words, one at a time, to a second register. The block keeps the words in an argument buffer until enough bytes have arrived for the current command. It then issues a one-cycle execute strobe that carries the command code and the buffered words. Later it captures the result code that the handler returns into a readable command status value. The handler that carries out the command is outside the block.

A per-command table sets how many argument bytes each code needs. Commands that need no arguments run on the command write itself. A code outside the legal range becomes the reserved "unknown" code 0, which needs no arguments, so it runs at once; its handler reports failure. Once a command has run, the stored code returns to unknown. After that, each stray data word runs the unknown command again.

The register writes are plain single-cycle strobes with no back-pressure. The block accepts every write in the cycle it is presented. If both strobes are high in the same cycle, the command write wins and the data word is dropped. The handler return is a single-cycle `res_valid` pulse and is never stalled.

Top module: `cmd_collector`

## Requirements
- R1: A command write stores its code only when the code is greater than 0 and less than 10. Any other value is stored as the unknown code 0.
- R2: A command write clears the argument word count. In the next cycle `cmd_status` reads not-enough-data (32'hFFFF_FFFE).
- R3: A data write stores its word at the current count position and advances the count. Word i appears on `exec_args[32*i +: 32]`.
- R4: `exec_stb` is high for exactly the one cycle after the triggering write. It is raised once the words received so far, times 4, reach the byte size the current code needs. `exec_code` carries that code during the pulse.
- R5: Byte sizes per code: codes 0, 2, 3, 6 and 8 need 0; code 1 needs 24; code 4 needs 32; code 5 needs 12; code 7 needs 16; code 9 needs 12.
- R6: After an execute, the stored code returns to 0 and the count to zero. A following data write with no new command write executes code 0.
- R7: When `res_valid` is pulsed while a result is awaited and no command write occurs in that cycle, `res_code` becomes `cmd_status` in the next cycle. A command write discards an awaited result, so a later `res_valid` leaves `cmd_status` unchanged.
- R8: After reset, `cmd_status` is success (0) and `exec_stb` is low.
- R9: The argument count never reaches the buffer depth (8 words), so no data write is ever dropped for lack of room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command code written |
| data_wr | input | 1 | Argument register write strobe |
| data_wdata | input | 32 | Argument word written |
| exec_stb | output | 1 | One-cycle execute request |
| exec_code | output | 4 | Command code to execute |
| exec_args | output | 256 | Argument words, word i at bits 32*i+31..32*i |
| res_valid | input | 1 | Handler result pulse |
| res_code | input | 32 | Handler result code |
| cmd_status | output | 32 | Command status register value |

## Verification
Several properties are checked on every cycle: every execute pulse follows a register write, only legal codes are executed, the status reads not-enough-data after any command write, an awaited result lands in the status, and the argument count stays below the buffer depth. Other behaviours can only be shown by the bench's scenarios, because they depend on the size table and the order of writes. These are the exact word on which each command fires, the argument word order, the collapse of illegal codes, the repeated execution of stray data words, the restart on a mid-collection command write, and the discarding of a stale result.

// File: rtl/cmdc_pkg.sv
package cmdc_pkg;
  localparam int unsigned CODE_W        = 4;
  localparam int unsigned CODE_LAST     = 10;
  localparam int unsigned MAX_ARG_WORDS = 8;
  localparam int unsigned SIZE_W        = 8;

  typedef logic [CODE_W-1:0] code_t;

  localparam logic [31:0] ST_OK   = 32'h0000_0000;
  localparam logic [31:0] ST_FAIL = 32'hFFFF_FFFF;
  localparam logic [31:0] ST_NED  = 32'hFFFF_FFFE;

  // argument bytes needed by each legal code
  function automatic logic [SIZE_W-1:0] arg_bytes(code_t c);
    case (c)
      4'd1:    arg_bytes = 8'd24;
      4'd4:    arg_bytes = 8'd32;
      4'd5:    arg_bytes = 8'd12;
      4'd7:    arg_bytes = 8'd16;
      4'd9:    arg_bytes = 8'd12;
      default: arg_bytes = 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/cmdc_decode.sv
module cmdc_decode #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]                 raw,
  output cmdc_pkg::code_t                   code,
  output logic [cmdc_pkg::SIZE_W-1:0]       need
);
  import cmdc_pkg::*;
  logic legal;
  assign legal = (raw > '0) && (raw < WORD_W'(CODE_LAST));
  assign code  = legal ? raw[CODE_W-1:0] : '0;
  assign need  = arg_bytes(code);
endmodule

// File: rtl/cmdc_argbuf.sv
module cmdc_argbuf #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [WORD_W-1:0]       wr_word,
  output logic [DEPTH*WORD_W-1:0] words
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 slot_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))    slot_q <= wr_word;
    end
    assign words[i*WORD_W +: WORD_W] = slot_q;
  end
endmodule

// File: rtl/cmd_collector.sv
module cmd_collector #(
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = cmdc_pkg::MAX_ARG_WORDS,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_wr,
  input  logic [WORD_W-1:0]           cmd_wdata,
  input  logic                        data_wr,
  input  logic [WORD_W-1:0]           data_wdata,
  output logic                        exec_stb,
  output logic [cmdc_pkg::CODE_W-1:0] exec_code,
  output logic [MAX_WORDS*WORD_W-1:0] exec_args,
  input  logic                        res_valid,
  input  logic [WORD_W-1:0]           res_code,
  output logic [WORD_W-1:0]           cmd_status
);
  import cmdc_pkg::*;

  code_t              cur_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               pending_q;
  code_t              new_code;
  logic [SIZE_W-1:0]  new_need;
  logic [SIZE_W-1:0]  cur_need;
  logic               room;
  logic               data_take;
  logic               reached;

  cmdc_decode #(.WORD_W(WORD_W)) u_dec (
    .raw  (cmd_wdata),
    .code (new_code),
    .need (new_need)
  );

  assign cur_need  = arg_bytes(cur_q);
  assign room      = (32'(cnt_q) < 32'(MAX_WORDS));
  assign data_take = data_wr && !cmd_wr && room;
  assign reached   = ((32'(cnt_q) + 32'd1) * 32'd4) >= 32'(cur_need);

  cmdc_argbuf #(.WORD_W(WORD_W), .DEPTH(MAX_WORDS)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (data_take),
    .wr_idx  (cnt_q),
    .wr_word (data_wdata),
    .words   (exec_args)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q      <= '0;
      cnt_q      <= '0;
      pending_q  <= 1'b0;
      exec_stb   <= 1'b0;
      exec_code  <= '0;
      cmd_status <= WORD_W'(ST_OK);
    end else begin
      exec_stb <= 1'b0;
      if (cmd_wr) begin
        cnt_q      <= '0;
        cmd_status <= WORD_W'(ST_NED);
        if (new_need == '0) begin
          exec_stb  <= 1'b1;
          exec_code <= new_code;
          cur_q     <= '0;
          pending_q <= 1'b1;
        end else begin
          cur_q     <= new_code;
          pending_q <= 1'b0;
        end
      end else begin
        if (res_valid && pending_q) begin
          cmd_status <= res_code;
          pending_q  <= 1'b0;
        end
        if (data_take) begin
          if (reached) begin
            exec_stb  <= 1'b1;
            exec_code <= cur_q;
            cur_q     <= '0;
            cnt_q     <= '0;
            pending_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cmdc_checker.sv
module cmdc_checker #(
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 8,
  parameter int CNT_W     = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cmd_wr,
  input logic                        data_wr,
  input logic                        exec_stb,
  input logic [cmdc_pkg::CODE_W-1:0] exec_code,
  input logic                        res_valid,
  input logic [WORD_W-1:0]           res_code,
  input logic [WORD_W-1:0]           cmd_status,
  input logic [CNT_W-1:0]            cnt,
  input logic                        pending
);
  assert_stb_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> $past(cmd_wr || data_wr));

  assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> (32'(exec_code) < 32'(cmdc_pkg::CODE_LAST)));

  assert_ned_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (cmd_status == WORD_W'(cmdc_pkg::ST_NED)));

  assert_result_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && pending && !cmd_wr) |=> (cmd_status == $past(res_code)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < 32'(MAX_WORDS));
endmodule

bind cmd_collector cmdc_checker #(
  .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
  .exec_stb(exec_stb), .exec_code(exec_code), .res_valid(res_valid),
  .res_code(res_code), .cmd_status(cmd_status), .cnt(cnt_q),
  .pending(pending_q)
);

// File: tb/cmd_collector_bench.sv
module cmd_collector_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_wr = 1'b0;
  logic [31:0]  cmd_wdata = '0;
  logic         data_wr = 1'b0;
  logic [31:0]  data_wdata = '0;
  logic         exec_stb;
  logic [3:0]   exec_code;
  logic [255:0] exec_args;
  logic         res_valid = 1'b0;
  logic [31:0]  res_code = '0;
  logic [31:0]  cmd_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] OK = 32'h0, FAIL = 32'hFFFF_FFFF, NED = 32'hFFFF_FFFE;

  always #10 clk = ~clk;

  cmd_collector u_cmd_collector (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .exec_stb(exec_stb),
    .exec_code(exec_code), .exec_args(exec_args), .res_valid(res_valid),
    .res_code(res_code), .cmd_status(cmd_status)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // each write task returns at the falling edge after the capturing edge
  task automatic wr_cmd(input logic [31:0] c);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = c;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [31:0] w);
    @(negedge clk); data_wr = 1'b1; data_wdata = w;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic respond(input logic [31:0] r);
    res_valid = 1'b1; res_code = r;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic expect_exec(input logic [3:0] code, input string tag);
    check(exec_stb === 1'b1, {tag, " strobe"}, 32'(exec_stb), 32'd1);
    check(exec_code === code, {tag, " code"}, 32'(exec_code), 32'(code));
  endtask

  task automatic t_reset;
    check(cmd_status === OK, "R8 status after reset", cmd_status, OK);
    check(exec_stb === 1'b0, "R8 no strobe after reset", 32'(exec_stb), 32'd0);
  endtask

  task automatic t_zero_size;
    wr_cmd(32'd6);
    expect_exec(4'd6, "R5 bus-reset runs on command write");
    check(cmd_status === NED, "R2 status pending", cmd_status, NED);
    respond(OK);
    check(exec_stb === 1'b0, "R4 strobe one cycle", 32'(exec_stb), 32'd0);
    check(cmd_status === OK, "R7 result latched", cmd_status, OK);
  endtask

  task automatic t_config;
    wr_cmd(32'd1);
    check(exec_stb === 1'b0, "R5 config waits", 32'(exec_stb), 32'd0);
    for (int i = 0; i < 5; i++) begin
      wr_data(32'hC0DE_0000 + 32'(i));
      check(exec_stb === 1'b0, "R4 no early exec", 32'(exec_stb), 32'd0);
    end
    check(cmd_status === NED, "R2 not enough data", cmd_status, NED);
    wr_data(32'hC0DE_0005);
    expect_exec(4'd1, "R4 config fires on sixth word");
    for (int i = 0; i < 6; i++)
      check(exec_args[32*i +: 32] === 32'hC0DE_0000 + 32'(i), "R3 word order",
            exec_args[32*i +: 32], 32'hC0DE_0000 + 32'(i));
    respond(FAIL);
    check(cmd_status === FAIL, "R7 failure latched", cmd_status, FAIL);
  endtask

  task automatic t_illegal;
    wr_cmd(32'd12);
    expect_exec(4'd0, "R1 code 12 collapses");
    wr_cmd(32'd10);
    expect_exec(4'd0, "R1 code 10 collapses");
    wr_cmd(32'h8000_0004);
    expect_exec(4'd0, "R1 large code collapses");
    respond(FAIL);
  endtask

  task automatic t_stray_data;
    wr_data(32'h1234_5678);
    expect_exec(4'd0, "R6 stray word runs unknown");
    check(exec_args[31:0] === 32'h1234_5678, "R3 stray word at slot 0",
          exec_args[31:0], 32'h1234_5678);
    wr_data(32'h0BAD_F00D);
    expect_exec(4'd0, "R6 second stray word runs unknown");
    respond(FAIL);
  endtask

  task automatic t_ring_setup;
    wr_cmd(32'd4);
    for (int i = 0; i < 7; i++) wr_data(32'hA000_0000 + 32'(i));
    check(exec_stb === 1'b0, "R5 ring setup needs 8 words", 32'(exec_stb), 32'd0);
    wr_data(32'hA000_0007);
    expect_exec(4'd4, "R4 ring setup fires");
    check(exec_args[255:224] === 32'hA000_0007, "R3 last slot",
          exec_args[255:224], 32'hA000_0007);
    respond(OK);
    check(cmd_status === OK, "R7 ring setup ok", cmd_status, OK);
  endtask

  task automatic t_restart;
    wr_cmd(32'd5);
    wr_data(32'h5555_0000);
    wr_data(32'h5555_0001);
    wr_cmd(32'd9);
    check(exec_stb === 1'b0, "R2 restart no exec", 32'(exec_stb), 32'd0);
    wr_data(32'h9999_0000);
    wr_data(32'h9999_0001);
    check(exec_stb === 1'b0, "R2 count restarted", 32'(exec_stb), 32'd0);
    wr_data(32'h9999_0002);
    expect_exec(4'd9, "R5 abort fires on third word");
    check(exec_args[31:0] === 32'h9999_0000, "R3 restart slot 0",
          exec_args[31:0], 32'h9999_0000);
    respond(OK);
    wr_cmd(32'd7);
    for (int i = 0; i < 3; i++) wr_data(32'h7);
    check(exec_stb === 1'b0, "R5 msg setup waits", 32'(exec_stb), 32'd0);
    wr_data(32'h7);
    expect_exec(4'd7, "R5 msg setup fires on fourth word");
    respond(OK);
  endtask

  task automatic t_stale_result;
    wr_cmd(32'd8);
    expect_exec(4'd8, "R5 adapter reset immediate");
    wr_cmd(32'd1);
    respond(32'h0000_00AA);
    check(cmd_status === NED, "R7 stale result dropped", cmd_status, NED);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_size();
    t_config();
    t_illegal();
    t_stray_data();
    t_ring_setup();
    t_restart();
    t_stale_result();
    finish_run();
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end
endmodule